// File: doc/BRIEF.md
# Fixed-Matrix Nodal Solution Engine

This block produces the unknown vector of a nodal circuit model once per simulation time step. The vector holds node voltages, inductor branch currents, switch branch currents and the DC source current. It forms the product of a constant inverse nodal admittance matrix and a right-hand-side vector. The right-hand side is built elsewhere from source values and from the history terms of the inductor and switch update units. Switches are modelled with a fixed conductance, so the matrix never changes during a run. Software writes it once into on-chip storage through an address/data/write-enable port while the engine is idle.

A start strobe takes a snapshot of the right-hand side and launches one solve. All values are signed fixed point, 40 bits wide, with 19 integer bits and 21 fractional bits. The product is split into independent row dot products. Each dot product multiplies every column in parallel and sums the products at full width. The engine processes `LANES` rows per clock. With the default 20×20 matrix and 4 lanes, a step takes the accepting edge plus five compute edges, which is six cycles. Results are committed together into an output register bank that the element-update units read during the next step. A one-cycle done strobe marks the commit.

Top module: `fixed_nodal_solver`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and every element of `x_o` is zero.
- R2: A write with `mat_row_i`=i and `mat_col_i`=j stores the coefficient that multiplies right-hand-side element j when output element i is formed. Vector element k occupies bits [k*40 +: 40] of `rhs_i` and of `x_o`. Writes with a row or column index of N or more are dropped.
- R3: Output element i equals the sum over j of A[i][j]·b[j], computed exactly and then shifted right by 21 bits to return to the 40-bit format with 21 fractional bits.
- R4: A result above 2^39−1 is replaced by 2^39−1. A result below −2^39 is replaced by −2^39.
- R5: The 21-bit shift truncates toward minus infinity. For example, −1 raw × 0.5 gives −1 raw, and 3 raw × −0.5 gives −2 raw.
- R6: `done_o` is high for exactly one cycle, after the GROUPS-th rising edge that follows the edge accepting `start_i` (GROUPS = ceil(N/LANES), 5 by default). `busy_o` is high from acceptance until that commit. A start held in the done cycle is accepted.
- R7: `rhs_i` is sampled only on the accepting edge. Changes to it during a solve do not affect that solve.
- R8: `x_o` keeps its previous contents during a solve. All of its elements change together, in the cycle when `done_o` is high.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It neither restarts nor lengthens the running solve.
- R10: Matrix writes presented while `busy_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mat_we_i | input | 1 | Matrix entry write enable |
| mat_row_i | input | $clog2(N) | Row index of the entry written |
| mat_col_i | input | $clog2(N) | Column index of the entry written |
| mat_data_i | input | 40 | Entry value, signed fixed point |
| start_i | input | 1 | Launch one solve |
| rhs_i | input | N*40 | Right-hand-side vector, element k at bits [k*40 +: 40] |
| busy_o | output | 1 | Solve in progress |
| done_o | output | 1 | One-cycle strobe when results commit |
| x_o | output | N*40 | Result register bank, element k at bits [k*40 +: 40] |

## Verification
A permuted unit matrix checks that row and column addresses and the vector bit slots line up. Small random matrices with random vectors exercise exact accumulation and rounding without hitting the limits. Full-scale matrices and vectors drive the positive and negative clamps. Separately, a hand-built case with half-unit coefficients tells floor rounding apart from rounding toward zero. During one solve the bench changes the vector, repeats start and writes a matrix entry, which shows the snapshot, the start lockout and the write lockout. A back-to-back launch in the done cycle confirms the six-cycle step rate.

// File: rtl/nodal_fx_pkg.sv
package nodal_fx_pkg;
  localparam int unsigned FX_W    = 40;
  localparam int unsigned FX_INT  = 19;
  localparam int unsigned FX_FRAC = FX_W - FX_INT;
  // Guard bits cover sums of up to 256 full-width products.
  localparam int unsigned ACC_W   = 2 * FX_W + 8;

  typedef logic signed [FX_W-1:0]  fx_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  localparam fx_t  FX_MAX = {1'b0, {(FX_W-1){1'b1}}};
  localparam fx_t  FX_MIN = {1'b1, {(FX_W-1){1'b0}}};
  localparam acc_t ACC_HI = acc_t'(FX_MAX);
  localparam acc_t ACC_LO = acc_t'(FX_MIN);

  // Full-width signed product.
  function automatic acc_t fx_mul(input fx_t a, input fx_t b);
    acc_t ae;
    acc_t be;
    ae = acc_t'(a);
    be = acc_t'(b);
    return ae * be;
  endfunction

  // Return a wide sum to the element format: floor shift, then clamp.
  function automatic fx_t fx_narrow(input acc_t s);
    acc_t q;
    q = s >>> FX_FRAC;
    if (q > ACC_HI) return FX_MAX;
    if (q < ACC_LO) return FX_MIN;
    return fx_t'(q[FX_W-1:0]);
  endfunction
endpackage

// File: rtl/coef_store.sv
module coef_store
  import nodal_fx_pkg::*;
#(
  parameter int unsigned N     = 20,
  parameter int unsigned LANES = 4,
  parameter int unsigned GRP_W = 3,
  parameter int unsigned ROW_W = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      lock_i,
  input  logic                      wr_en_i,
  input  logic [ROW_W-1:0]          wr_row_i,
  input  logic [ROW_W-1:0]          wr_col_i,
  input  logic [FX_W-1:0]           wr_data_i,
  input  logic [GRP_W-1:0]          rd_grp_i,
  output logic [LANES*N*FX_W-1:0]   rows_o,
  output logic [LANES-1:0]          valid_o
);
  localparam int unsigned ROW_BITS = N * FX_W;

  logic [N*ROW_BITS-1:0] mem_q;
  logic                  wr_take;
  int                    wr_idx;

  always_comb begin
    wr_take = wr_en_i && !lock_i &&
              ({1'b0, wr_row_i} < (ROW_W+1)'(N)) &&
              ({1'b0, wr_col_i} < (ROW_W+1)'(N));
    wr_idx  = int'(wr_row_i) * N + int'(wr_col_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mem_q <= '0;
    end else if (wr_take) begin
      mem_q[wr_idx*FX_W +: FX_W] <= wr_data_i;
    end
  end

  // Lane l of group g reads row g*LANES + l; lanes past the last row idle.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ROW_W:0] ridx;
    assign ridx       = (ROW_W+1)'(int'(rd_grp_i) * LANES + l);
    assign valid_o[l] = (ridx < (ROW_W+1)'(N));
    assign rows_o[l*ROW_BITS +: ROW_BITS] =
      valid_o[l] ? mem_q[ridx*ROW_BITS +: ROW_BITS] : '0;
  end

  assert_write_locked_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (lock_i && wr_en_i) |=> $stable(mem_q));
endmodule

// File: rtl/row_dot.sv
module row_dot
  import nodal_fx_pkg::*;
#(
  parameter int unsigned N = 20
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              valid_i,
  input  logic [N*FX_W-1:0] coef_i,
  input  logic [N*FX_W-1:0] rhs_i,
  output fx_t               y_o
);
  acc_t prod [N];
  acc_t sum_w;

  // All column products in parallel.
  for (genvar c = 0; c < N; c++) begin : g_mul
    assign prod[c] = fx_mul(fx_t'(coef_i[c*FX_W +: FX_W]),
                            fx_t'(rhs_i[c*FX_W +: FX_W]));
  end

  always_comb begin
    sum_w = '0;
    for (int c = 0; c < N; c++) sum_w = sum_w + prod[c];
  end

  assign y_o = fx_narrow(sum_w);

  // Floor rounding and clamping never flip the sign of the sum.
  assert_sign_kept_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    valid_i |-> ((sum_w < 0) == (y_o < 0)));
endmodule

// File: rtl/solve_ctrl.sv
module solve_ctrl #(
  parameter int unsigned GROUPS = 5,
  parameter int unsigned GRP_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             accept_o,
  output logic             last_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             done_o
);
  logic             busy_q;
  logic             done_q;
  logic [GRP_W-1:0] grp_q;
  logic [GRP_W:0]   run_q;

  assign accept_o = start_i && !busy_q;
  assign last_o   = busy_q && (grp_q == GRP_W'(GROUPS - 1));
  assign busy_o   = busy_q;
  assign grp_o    = grp_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      grp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        grp_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
        grp_q  <= '0;
      end else if (busy_q) begin
        grp_q  <= grp_q + GRP_W'(1);
      end
    end
  end

  // Checker counter: edges spent busy since acceptance.
  always_ff @(posedge clk_i) begin
    if (rst_i)         run_q <= '0;
    else if (accept_o) run_q <= '0;
    else if (busy_q)   run_q <= run_q + (GRP_W+1)'(1);
  end

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |=> !done_q);
  assert_done_ends_busy_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |-> (!busy_q && $past(busy_q)));
  assert_latency_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    done_q |-> (run_q == (GRP_W+1)'(GROUPS)));
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && start_i && !last_o) |=> (busy_q && grp_q == $past(grp_q) + GRP_W'(1)));
endmodule

// File: rtl/fixed_nodal_solver.sv
module fixed_nodal_solver
  import nodal_fx_pkg::*;
#(
  parameter int unsigned N     = 20,
  parameter int unsigned LANES = 4,
  parameter int unsigned ROW_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              mat_we_i,
  input  logic [ROW_W-1:0]  mat_row_i,
  input  logic [ROW_W-1:0]  mat_col_i,
  input  logic [FX_W-1:0]   mat_data_i,
  input  logic              start_i,
  input  logic [N*FX_W-1:0] rhs_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [N*FX_W-1:0] x_o
);
  localparam int unsigned GROUPS = (N + LANES - 1) / LANES;
  localparam int unsigned GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic                    accept;
  logic                    last;
  logic [GRP_W-1:0]        grp;
  logic [LANES*N*FX_W-1:0] lane_rows;
  logic [LANES-1:0]        lane_valid;
  fx_t                     lane_y [LANES];
  logic [N*FX_W-1:0]       rhs_q;
  fx_t                     shadow_q [N];
  fx_t                     x_q [N];

  solve_ctrl #(.GROUPS(GROUPS), .GRP_W(GRP_W)) u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
    .busy_o(busy_o), .accept_o(accept), .last_o(last),
    .grp_o(grp), .done_o(done_o)
  );

  coef_store #(.N(N), .LANES(LANES), .GRP_W(GRP_W), .ROW_W(ROW_W)) u_store (
    .clk_i(clk_i), .rst_i(rst_i), .lock_i(busy_o),
    .wr_en_i(mat_we_i), .wr_row_i(mat_row_i), .wr_col_i(mat_col_i),
    .wr_data_i(mat_data_i), .rd_grp_i(grp),
    .rows_o(lane_rows), .valid_o(lane_valid)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_dot
    row_dot #(.N(N)) u_dot (
      .clk_i(clk_i), .rst_i(rst_i),
      .valid_i(busy_o && lane_valid[l]),
      .coef_i(lane_rows[l*N*FX_W +: N*FX_W]),
      .rhs_i(rhs_q),
      .y_o(lane_y[l])
    );
  end

  // Snapshot of the right-hand side, taken only on acceptance.
  always_ff @(posedge clk_i) begin
    if (rst_i)       rhs_q <= '0;
    else if (accept) rhs_q <= rhs_i;
  end

  // Rows land in the shadow bank group by group; the last group commits all.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int r = 0; r < N; r++) begin
        shadow_q[r] <= '0;
        x_q[r]      <= '0;
      end
    end else if (busy_o) begin
      for (int r = 0; r < N; r++) begin
        if (grp == GRP_W'(r / LANES)) shadow_q[r] <= lane_y[r % LANES];
        if (last) x_q[r] <= (grp == GRP_W'(r / LANES)) ? lane_y[r % LANES] : shadow_q[r];
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_out
    assign x_o[r*FX_W +: FX_W] = x_q[r];
  end

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(x_o) |-> done_o);
  assert_rhs_frozen_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |=> $stable(rhs_q));
  assert_idle_after_reset_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!busy_o && !done_o));
endmodule

// File: tb/sim_fixed_nodal_solver.sv
module sim_fixed_nodal_solver;
  localparam int N      = 20;
  localparam int LANES  = 4;
  localparam int ROW_W  = $clog2(N);
  localparam int GROUPS = (N + LANES - 1) / LANES;
  localparam logic signed [39:0] ONE  = 40'sd1 <<< 21;
  localparam logic signed [39:0] HALF = 40'sd1 <<< 20;
  localparam logic signed [39:0] TOP  = 40'sh7FFFFFFFFF;
  localparam logic signed [39:0] BOT  = 40'sh8000000000;

  logic              clk_i = 1'b0;
  logic              rst_i = 1'b1;
  logic              mat_we_i = 1'b0;
  logic [ROW_W-1:0]  mat_row_i = '0;
  logic [ROW_W-1:0]  mat_col_i = '0;
  logic [39:0]       mat_data_i = '0;
  logic              start_i = 1'b0;
  logic [N*40-1:0]   rhs_i = '0;
  logic              busy_o;
  logic              done_o;
  logic [N*40-1:0]   x_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic signed [39:0] am [N][N];
  logic signed [39:0] bv [N];

  always #2 clk_i = ~clk_i;

  fixed_nodal_solver #(.N(N), .LANES(LANES)) u0 (
    .clk_i(clk_i), .rst_i(rst_i), .mat_we_i(mat_we_i), .mat_row_i(mat_row_i),
    .mat_col_i(mat_col_i), .mat_data_i(mat_data_i), .start_i(start_i),
    .rhs_i(rhs_i), .busy_o(busy_o), .done_o(done_o), .x_o(x_o)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Exact wide sum, floor shift, clamp (R3 R4 R5).
  function automatic logic signed [39:0] expect_row(input int r);
    logic signed [127:0] acc;
    acc = '0;
    for (int c = 0; c < N; c++) acc = acc + 128'(am[r][c]) * 128'(bv[c]);
    acc = acc >>> 21;
    if (acc > 128'(TOP)) return TOP;
    if (acc < 128'(BOT)) return BOT;
    return acc[39:0];
  endfunction

  function automatic logic signed [39:0] small_rand(input int sh);
    logic signed [31:0] v;
    v = $signed(32'($urandom));
    return 40'(v >>> sh);
  endfunction

  task automatic load_all();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        mat_we_i = 1'b1; mat_row_i = ROW_W'(r); mat_col_i = ROW_W'(c);
        mat_data_i = am[r][c];
        @(negedge clk_i);
      end
    mat_we_i = 1'b0;
  endtask

  task automatic run_solve(input string tag, input bit perturb, input bit b2b);
    logic [N*40-1:0] prev;
    int k;
    bit hold_ok;
    prev = x_o;
    for (int r = 0; r < N; r++) rhs_i[r*40 +: 40] = bv[r];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, {"R6 busy after start ", tag}, longint'(busy_o), 1);
    k = 0;
    hold_ok = 1'b1;
    while (!done_o && k < 20) begin
      if (x_o != prev) hold_ok = 1'b0;
      if (perturb && k == 1) begin
        for (int r = 0; r < N; r++) rhs_i[r*40 +: 40] = {8'($urandom), 32'($urandom)};
        start_i = 1'b1;
        mat_we_i = 1'b1; mat_row_i = '0; mat_col_i = '0; mat_data_i = 40'h5A5A5A5A5A;
      end else begin
        start_i = 1'b0;
        mat_we_i = 1'b0;
      end
      @(negedge clk_i);
      k++;
    end
    start_i = 1'b0;
    mat_we_i = 1'b0;
    chk(hold_ok, {"R8 x_o held during solve ", tag}, longint'(hold_ok), 1);
    chk(k == GROUPS, {"R6 R9 latency ", tag}, k, GROUPS);
    chk(busy_o == 1'b0, {"R6 busy cleared ", tag}, longint'(busy_o), 0);
    for (int r = 0; r < N; r++) begin
      logic signed [39:0] got;
      logic signed [39:0] exp;
      got = x_o[r*40 +: 40];
      exp = expect_row(r);
      chk(got == exp, $sformatf("R3 R7 R10 %s x[%0d]", tag, r), got, exp);
    end
    if (!b2b) begin
      @(negedge clk_i);
      chk(done_o == 1'b0, {"R6 done single cycle ", tag}, longint'(done_o), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    rst_i = 1'b0;
    @(negedge clk_i);
    // R1
    chk(busy_o == 1'b0, "R1 busy after reset", longint'(busy_o), 0);
    chk(done_o == 1'b0, "R1 done after reset", longint'(done_o), 0);
    chk(x_o == '0, "R1 x_o after reset", longint'(x_o[39:0]), 0);

    // R2: permuted unit matrix, x[i] = b[(i+3) mod N]
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) am[r][c] = (c == (r + 3) % N) ? ONE : '0;
    load_all();
    for (int r = 0; r < N; r++) bv[r] = small_rand(2);
    run_solve("R2 permutation", 1'b0, 1'b0);

    // R3: random small matrices; one perturbed (R7 R9 R10), one back-to-back (R6)
    for (int t = 0; t < 3; t++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) am[r][c] = small_rand(9);
      load_all();
      for (int r = 0; r < N; r++) bv[r] = small_rand(5);
      run_solve("R3 random", t == 1, 1'b1);
      for (int r = 0; r < N; r++) bv[r] = small_rand(5);
      run_solve("R6 back-to-back", 1'b0, 1'b0);
    end

    // R4: clamps in both directions, then a full-range vector
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) am[r][c] = TOP;
    load_all();
    for (int r = 0; r < N; r++) bv[r] = TOP;
    run_solve("R4 positive clamp", 1'b0, 1'b0);
    chk(x_o[39:0] == TOP, "R4 top value", longint'($signed(x_o[39:0])), TOP);
    for (int r = 0; r < N; r++) bv[r] = BOT;
    run_solve("R4 negative clamp", 1'b0, 1'b0);
    chk(x_o[39:0] == BOT, "R4 bottom value", longint'($signed(x_o[39:0])), BOT);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) am[r][c] = small_rand(6);
    load_all();
    for (int r = 0; r < N; r++) bv[r] = {8'($urandom), 32'($urandom)};
    run_solve("R4 full-range", 1'b0, 1'b0);

    // R5: floor rounding of half-unit products
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) am[r][c] = '0;
    am[0][0] = HALF; am[1][1] = HALF; am[2][2] = -HALF;
    load_all();
    for (int r = 0; r < N; r++) bv[r] = '0;
    bv[0] = -40'sd1; bv[1] = 40'sd1; bv[2] = 40'sd3;
    run_solve("R5 floor", 1'b0, 1'b0);
    chk($signed(x_o[39:0]) == -40'sd1, "R5 -1*0.5", longint'($signed(x_o[39:0])), -1);
    chk($signed(x_o[119:80]) == -40'sd2, "R5 3*-0.5", longint'($signed(x_o[119:80])), -2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule